// File: doc/BRIEF.md
# Shared Instruction/Data Local Memory Hub

This block sits between a processor's fetch port, its load/store port and a private local memory built from a true dual-port RAM. Each side owns one RAM port, so an instruction fetch and a data access that both land in the local window are accepted in the same cycle and answered together one cycle later. The local memory has a fixed, short latency and cannot be reached from the external bus. The data side can read and write all of it, including the words the processor executes from, so a debugger or loader can place and patch code there.

Any request whose address lies outside the window goes to a single external bus master that both sides share. Only one external transaction is in flight at a time. When both sides need the external bus in the same cycle, the data side is served first. A request that has been presented to the external bus but not yet accepted keeps its place until it is accepted. A side that is waiting for an external response takes no new request until that response arrives, so each side gets its responses back in the order it issued them. The window base and size are parameters, and the size is a power of two.

Top module: `tcm_hub`

## Requirements
- R1: An address hits the local window when its bits above log2(TCM_BYTES) equal those of TCM_BASE. All other addresses, including the word just below the base and the first word past the end, go to the external master.
- R2: With no external response pending on that side, a local hit sees its ready high in the same cycle it is presented. Its response valid is high exactly one clock after acceptance and carries the word read.
- R3: A fetch and a data access that both hit the window in the same cycle are both accepted in that cycle. Both respond on the following cycle with correct data.
- R4: Data writes to the window are visible to later data reads and to later instruction fetches of the same word.
- R5: Write strobe bit i enables byte lane data[8i+7:8i]. A lane whose strobe bit is 0 keeps its old content.
- R6: If a data write and a fetch target the same local word in the same cycle, the fetch returns the value the word held before the write.
- R7: A miss appears on the external master with its address unchanged. Data requests also carry their write flag, write data and strobes; a fetch carries write=0 and strobes 0. The external response data is returned to the side that issued the request.
- R8: When neither side has a request waiting for acceptance and both present a miss in the same cycle, the data request is put on the external master first. The fetch is held until the data transaction completes.
- R9: At most one external transaction is outstanding. While ext_req_ready is low, the presented external request keeps the same owner and address, even if the other side starts requesting.
- R10: A side with an outstanding external request keeps its ready low until the response arrives, so its responses stay in issue order. Meanwhile the other side's local hits continue at full rate.
- R11: During and right after reset, no response valid and no external request valid is asserted.
- R12: A request that hits the window never raises ext_req_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req_valid | input | 1 | Fetch request valid |
| if_req_addr | input | ADDR_W | Fetch byte address |
| if_req_ready | output | 1 | Fetch request accepted this cycle |
| if_rsp_valid | output | 1 | Fetch response valid |
| if_rsp_data | output | DATA_W | Fetched word |
| dt_req_valid | input | 1 | Data request valid |
| dt_req_addr | input | ADDR_W | Data byte address |
| dt_req_write | input | 1 | 1 = write, 0 = read |
| dt_req_wdata | input | DATA_W | Write data |
| dt_req_strb | input | DATA_W/8 | Byte-lane write enables |
| dt_req_ready | output | 1 | Data request accepted this cycle |
| dt_rsp_valid | output | 1 | Data response valid |
| dt_rsp_data | output | DATA_W | Read data |
| ext_req_valid | output | 1 | External request valid |
| ext_req_ready | input | 1 | External bus accepts request |
| ext_req_addr | output | ADDR_W | External address |
| ext_req_write | output | 1 | External write flag |
| ext_req_wdata | output | DATA_W | External write data |
| ext_req_strb | output | DATA_W/8 | External byte enables |
| ext_rsp_valid | input | 1 | External response valid, one per accepted request |
| ext_rsp_data | input | DATA_W | External response data |

## Verification
Two pairs of events can fall in the same cycle. A fetch and a data access can both reach the local RAM, and both sides can both want the external bus. The bench sweeps every local word with a same-cycle fetch plus data write to that same word, and with a fetch plus data read of a different word. It expects the old word on the fetch side and correct data on both sides one cycle later. Simultaneous misses are judged by which address shows up first on the external master, by the fetch's ready staying low until the data response has been seen, and by a request waiting under a low ext_req_ready keeping its owner when the other side starts requesting.

// File: rtl/tcm_hub_pkg.sv
`timescale 1ns/1ps
package tcm_hub_pkg;
  // Which processor side owns an external transaction.
  typedef enum logic {
    SIDE_INSTR = 1'b0,
    SIDE_DATA  = 1'b1
  } side_e;
endpackage

// File: rtl/tcm_hub_dpram.sv
`timescale 1ns/1ps
// True dual-port local RAM: port A read-only (fetch), port B read/write
// with byte-lane enables (data). Reads return the pre-edge content.
module tcm_hub_dpram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic                    clk,
  input  logic                    a_en,
  input  logic [$clog2(DEPTH)-1:0] a_idx,
  output logic [DATA_W-1:0]       a_q,
  input  logic                    b_en,
  input  logic                    b_we,
  input  logic [DATA_W/8-1:0]     b_strb,
  input  logic [$clog2(DEPTH)-1:0] b_idx,
  input  logic [DATA_W-1:0]       b_wdata,
  output logic [DATA_W-1:0]       b_q
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      a_q <= mem[a_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (b_en) begin
      b_q <= mem[b_idx];
      if (b_we) begin
        for (int l = 0; l < LANES; l++) begin
          if (b_strb[l]) begin
            mem[b_idx][l*8 +: 8] <= b_wdata[l*8 +: 8];
          end
        end
      end
    end
  end
endmodule

// File: rtl/tcm_hub_side.sv
`timescale 1ns/1ps
// Per-side request tracker: window decode, acceptance, response routing.
module tcm_hub_side #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                TCM_BYTES = 4096,
  parameter logic [ADDR_W-1:0] TCM_BASE  = '0,
  localparam int OFS_W = $clog2(DATA_W / 8),
  localparam int WIN_W = $clog2(TCM_BYTES),
  localparam int IDX_W = WIN_W - OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-OFS_W-1:0] req_word,
  output logic                    req_ready,
  output logic                    want_ext,
  input  logic                    grant,
  input  logic                    ext_ready,
  input  logic                    ext_rsp_mine,
  input  logic [DATA_W-1:0]       ext_rsp_data,
  output logic                    ram_en,
  output logic [IDX_W-1:0]        ram_idx,
  input  logic [DATA_W-1:0]       ram_q,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data
);
  logic hit;
  logic ext_fire;
  logic pend_tcm_q, pend_tcm_d;
  logic pend_ext_q, pend_ext_d;

  always_comb begin
    hit       = (req_word[ADDR_W-OFS_W-1:IDX_W] == TCM_BASE[ADDR_W-1:WIN_W]);
    ram_en    = req_valid & hit & ~pend_ext_q;
    ram_idx   = req_word[IDX_W-1:0];
    want_ext  = req_valid & ~hit & ~pend_ext_q;
    ext_fire  = want_ext & grant & ext_ready;
    req_ready = ~pend_ext_q & (hit | (grant & ext_ready));
  end

  always_comb begin
    pend_tcm_d = ram_en;
    pend_ext_d = pend_ext_q;
    if (pend_ext_q) begin
      if (ext_rsp_mine) pend_ext_d = 1'b0;
    end else if (ext_fire) begin
      pend_ext_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tcm_q <= 1'b0;
      pend_ext_q <= 1'b0;
    end else begin
      pend_tcm_q <= pend_tcm_d;
      pend_ext_q <= pend_ext_d;
    end
  end

  always_comb begin
    rsp_valid = pend_tcm_q | (pend_ext_q & ext_rsp_mine);
    rsp_data  = pend_tcm_q ? ram_q : ext_rsp_data;
  end

  p_hit_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> rsp_valid);

  p_wait_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fire && !ext_rsp_mine) |=> !req_ready);
endmodule

// File: rtl/tcm_hub_xarb.sv
`timescale 1ns/1ps
// External master arbiter: data first, request held until accepted,
// one transaction in flight.
module tcm_hub_xarb
  import tcm_hub_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dt_want,
  input  logic  if_want,
  input  logic  ext_req_ready,
  input  logic  ext_rsp_valid,
  output logic  ext_valid,
  output side_e sel,
  output logic  dt_grant,
  output logic  if_grant,
  output logic  busy,
  output side_e owner
);
  logic  busy_q, busy_d;
  side_e owner_q, owner_d;
  logic  hold_q, hold_d;
  side_e hold_side_q, hold_side_d;
  logic  want_sel;
  logic  accept;

  always_comb begin
    if (hold_q)       sel = hold_side_q;
    else if (dt_want) sel = SIDE_DATA;
    else              sel = SIDE_INSTR;
    want_sel  = (sel == SIDE_DATA) ? dt_want : if_want;
    ext_valid = ~busy_q & want_sel;
    accept    = ext_valid & ext_req_ready;
    dt_grant  = ext_valid & (sel == SIDE_DATA);
    if_grant  = ext_valid & (sel == SIDE_INSTR);
  end

  always_comb begin
    busy_d      = busy_q ? ~ext_rsp_valid : accept;
    owner_d     = accept ? sel : owner_q;
    hold_d      = ext_valid & ~ext_req_ready;
    hold_side_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      owner_q     <= SIDE_INSTR;
      hold_q      <= 1'b0;
      hold_side_q <= SIDE_INSTR;
    end else begin
      busy_q      <= busy_d;
      owner_q     <= owner_d;
      hold_q      <= hold_d;
      hold_side_q <= hold_side_d;
    end
  end

  assign busy  = busy_q;
  assign owner = owner_q;

  p_data_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !hold_q && dt_want && if_want) |-> (dt_grant && !if_grant));

  p_single_txn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && ext_req_ready) |=> !ext_valid);
endmodule

// File: rtl/tcm_hub.sv
`timescale 1ns/1ps
module tcm_hub
  import tcm_hub_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                TCM_BYTES = 4096,
  parameter logic [ADDR_W-1:0] TCM_BASE  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  if_req_valid,
  input  logic [ADDR_W-1:0]     if_req_addr,
  output logic                  if_req_ready,
  output logic                  if_rsp_valid,
  output logic [DATA_W-1:0]     if_rsp_data,
  input  logic                  dt_req_valid,
  input  logic [ADDR_W-1:0]     dt_req_addr,
  input  logic                  dt_req_write,
  input  logic [DATA_W-1:0]     dt_req_wdata,
  input  logic [DATA_W/8-1:0]   dt_req_strb,
  output logic                  dt_req_ready,
  output logic                  dt_rsp_valid,
  output logic [DATA_W-1:0]     dt_rsp_data,
  output logic                  ext_req_valid,
  input  logic                  ext_req_ready,
  output logic [ADDR_W-1:0]     ext_req_addr,
  output logic                  ext_req_write,
  output logic [DATA_W-1:0]     ext_req_wdata,
  output logic [DATA_W/8-1:0]   ext_req_strb,
  input  logic                  ext_rsp_valid,
  input  logic [DATA_W-1:0]     ext_rsp_data
);
  localparam int STRB_W = DATA_W / 8;
  localparam int OFS_W  = $clog2(STRB_W);
  localparam int WIN_W  = $clog2(TCM_BYTES);
  localparam int IDX_W  = WIN_W - OFS_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic             if_want, dt_want;
  logic             if_grant, dt_grant;
  logic             if_mine, dt_mine;
  logic             if_ram_en, dt_ram_en;
  logic [IDX_W-1:0] if_ram_idx, dt_ram_idx;
  logic [DATA_W-1:0] if_ram_q, dt_ram_q;
  side_e            sel, owner;
  logic             busy;

  tcm_hub_side #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TCM_BYTES(TCM_BYTES), .TCM_BASE(TCM_BASE)
  ) i_if_side (
    .clk(clk), .rst_n(rst_n),
    .req_valid(if_req_valid), .req_word(if_req_addr[ADDR_W-1:OFS_W]),
    .req_ready(if_req_ready), .want_ext(if_want), .grant(if_grant),
    .ext_ready(ext_req_ready), .ext_rsp_mine(if_mine), .ext_rsp_data(ext_rsp_data),
    .ram_en(if_ram_en), .ram_idx(if_ram_idx), .ram_q(if_ram_q),
    .rsp_valid(if_rsp_valid), .rsp_data(if_rsp_data)
  );

  tcm_hub_side #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TCM_BYTES(TCM_BYTES), .TCM_BASE(TCM_BASE)
  ) i_dt_side (
    .clk(clk), .rst_n(rst_n),
    .req_valid(dt_req_valid), .req_word(dt_req_addr[ADDR_W-1:OFS_W]),
    .req_ready(dt_req_ready), .want_ext(dt_want), .grant(dt_grant),
    .ext_ready(ext_req_ready), .ext_rsp_mine(dt_mine), .ext_rsp_data(ext_rsp_data),
    .ram_en(dt_ram_en), .ram_idx(dt_ram_idx), .ram_q(dt_ram_q),
    .rsp_valid(dt_rsp_valid), .rsp_data(dt_rsp_data)
  );

  tcm_hub_xarb i_xarb (
    .clk(clk), .rst_n(rst_n),
    .dt_want(dt_want), .if_want(if_want),
    .ext_req_ready(ext_req_ready), .ext_rsp_valid(ext_rsp_valid),
    .ext_valid(ext_req_valid), .sel(sel),
    .dt_grant(dt_grant), .if_grant(if_grant),
    .busy(busy), .owner(owner)
  );

  tcm_hub_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
    .clk(clk),
    .a_en(if_ram_en), .a_idx(if_ram_idx), .a_q(if_ram_q),
    .b_en(dt_ram_en), .b_we(dt_req_write), .b_strb(dt_req_strb),
    .b_idx(dt_ram_idx), .b_wdata(dt_req_wdata), .b_q(dt_ram_q)
  );

  always_comb begin
    if_mine       = ext_rsp_valid & busy & (owner == SIDE_INSTR);
    dt_mine       = ext_rsp_valid & busy & (owner == SIDE_DATA);
    ext_req_addr  = (sel == SIDE_DATA) ? dt_req_addr : if_req_addr;
    ext_req_write = (sel == SIDE_DATA) & dt_req_write;
    ext_req_wdata = dt_req_wdata;
    ext_req_strb  = (sel == SIDE_DATA) ? dt_req_strb : '0;
  end

  p_no_tcm_leak_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid |-> (ext_req_addr[ADDR_W-1:WIN_W] != TCM_BASE[ADDR_W-1:WIN_W]));

  p_held_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_valid && !ext_req_ready) |=> (ext_req_valid && $stable(ext_req_addr)));

  p_ext_rsp_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rsp_valid && busy) |-> ((owner == SIDE_DATA) ? dt_rsp_valid : if_rsp_valid));

  p_dual_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (if_ram_en && dt_ram_en) |=> (if_rsp_valid && dt_rsp_valid));
endmodule

// File: tb/test_tcm_hub.sv
`timescale 1ns/1ps
module test_tcm_hub;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam int          BYTES = 64;
  localparam int          WORDS = BYTES / 4;
  localparam logic [31:0] XMASK = 32'h5A5A_0000;

  logic        clk, rst_n;
  logic        if_req_valid, if_req_ready, if_rsp_valid;
  logic [31:0] if_req_addr, if_rsp_data;
  logic        dt_req_valid, dt_req_write, dt_req_ready, dt_rsp_valid;
  logic [31:0] dt_req_addr, dt_req_wdata, dt_rsp_data;
  logic [3:0]  dt_req_strb;
  logic        ext_req_valid, ext_req_ready, ext_req_write, ext_rsp_valid;
  logic [31:0] ext_req_addr, ext_req_wdata, ext_rsp_data;
  logic [3:0]  ext_req_strb;

  int n_vec, n_bad;
  logic [31:0] mdl [WORDS];

  // external slave model
  logic m_pend;
  int   m_cnt, ext_lat;
  logic [31:0] m_addr;

  tcm_hub #(.ADDR_W(32), .DATA_W(32), .TCM_BYTES(BYTES), .TCM_BASE(BASE)) i_tcm_hub (
    .clk(clk), .rst_n(rst_n),
    .if_req_valid(if_req_valid), .if_req_addr(if_req_addr), .if_req_ready(if_req_ready),
    .if_rsp_valid(if_rsp_valid), .if_rsp_data(if_rsp_data),
    .dt_req_valid(dt_req_valid), .dt_req_addr(dt_req_addr), .dt_req_write(dt_req_write),
    .dt_req_wdata(dt_req_wdata), .dt_req_strb(dt_req_strb), .dt_req_ready(dt_req_ready),
    .dt_rsp_valid(dt_rsp_valid), .dt_rsp_data(dt_rsp_data),
    .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready), .ext_req_addr(ext_req_addr),
    .ext_req_write(ext_req_write), .ext_req_wdata(ext_req_wdata), .ext_req_strb(ext_req_strb),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 1'b0; m_cnt <= 0; m_addr <= '0;
      ext_rsp_valid <= 1'b0; ext_rsp_data <= '0;
    end else begin
      ext_rsp_valid <= 1'b0;
      if (m_pend) begin
        if (m_cnt == 0) begin
          ext_rsp_valid <= 1'b1;
          ext_rsp_data  <= m_addr ^ XMASK;
          m_pend <= 1'b0;
        end else begin
          m_cnt <= m_cnt - 1;
        end
      end else if (ext_req_valid && ext_req_ready) begin
        m_pend <= 1'b1; m_cnt <= ext_lat; m_addr <= ext_req_addr;
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] st);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (st[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] waddr(input int w);
    return BASE + 32'(w * 4);
  endfunction

  task automatic dt_tcm(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                        input logic [3:0] st, output logic [31:0] rd);
    @(negedge clk);
    dt_req_valid = 1'b1; dt_req_addr = a; dt_req_write = wr; dt_req_wdata = wd; dt_req_strb = st;
    #1;
    check("R2 data hit ready", 32'(dt_req_ready), 32'd1);
    check("R12 hit kept local", 32'(ext_req_valid), 32'd0);
    @(negedge clk);
    dt_req_valid = 1'b0; dt_req_write = 1'b0;
    check("R2 data rsp next cycle", 32'(dt_rsp_valid), 32'd1);
    rd = dt_rsp_data;
  endtask

  task automatic if_tcm(input logic [31:0] a, output logic [31:0] rd);
    @(negedge clk);
    if_req_valid = 1'b1; if_req_addr = a;
    #1;
    check("R2 fetch hit ready", 32'(if_req_ready), 32'd1);
    @(negedge clk);
    if_req_valid = 1'b0;
    check("R2 fetch rsp next cycle", 32'(if_rsp_valid), 32'd1);
    rd = if_rsp_data;
  endtask

  task automatic pair(input logic [31:0] ia, input logic [31:0] da, input logic wr,
                      input logic [31:0] wd, output logic [31:0] ird, output logic [31:0] drd);
    @(negedge clk);
    if_req_valid = 1'b1; if_req_addr = ia;
    dt_req_valid = 1'b1; dt_req_addr = da; dt_req_write = wr; dt_req_wdata = wd; dt_req_strb = 4'hF;
    #1;
    check("R3 both ready", {30'b0, if_req_ready, dt_req_ready}, 32'd3);
    @(negedge clk);
    if_req_valid = 1'b0; dt_req_valid = 1'b0; dt_req_write = 1'b0;
    check("R3 both respond", {30'b0, if_rsp_valid, dt_rsp_valid}, 32'd3);
    ird = if_rsp_data; drd = dt_rsp_data;
  endtask

  task automatic dt_ext(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                        input logic [3:0] st, output logic [31:0] rd);
    int g;
    @(negedge clk);
    dt_req_valid = 1'b1; dt_req_addr = a; dt_req_write = wr; dt_req_wdata = wd; dt_req_strb = st;
    #1; g = 0;
    while (!dt_req_ready && g < 100) begin @(negedge clk); #1; g++; end
    check("R7 ext addr", ext_req_addr, a);
    check("R7 ext write flag", 32'(ext_req_write), 32'(wr));
    check("R7 ext strobes", 32'(ext_req_strb), 32'(st));
    if (wr) check("R7 ext wdata", ext_req_wdata, wd);
    @(negedge clk);
    dt_req_valid = 1'b0; dt_req_write = 1'b0; g = 0;
    while (!dt_rsp_valid && g < 100) begin @(negedge clk); g++; end
    check("R7 data ext rsp", 32'(dt_rsp_valid), 32'd1);
    rd = dt_rsp_data;
  endtask

  task automatic if_ext(input logic [31:0] a, output logic [31:0] rd);
    int g;
    @(negedge clk);
    if_req_valid = 1'b1; if_req_addr = a;
    #1; g = 0;
    while (!if_req_ready && g < 100) begin @(negedge clk); #1; g++; end
    check("R7 fetch ext addr", ext_req_addr, a);
    check("R7 fetch ext no write", {27'b0, ext_req_write, ext_req_strb}, 32'd0);
    @(negedge clk);
    if_req_valid = 1'b0; g = 0;
    while (!if_rsp_valid && g < 100) begin @(negedge clk); g++; end
    check("R7 fetch ext rsp", 32'(if_rsp_valid), 32'd1);
    rd = if_rsp_data;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_vec++; n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] rd, ird, drd, wd, a_i, a_d;
    int g;
    logic seen;
    n_vec = 0; n_bad = 0; ext_lat = 1;
    rst_n = 1'b0; ext_req_ready = 1'b1;
    if_req_valid = 0; if_req_addr = '0;
    dt_req_valid = 0; dt_req_addr = '0; dt_req_write = 0; dt_req_wdata = '0; dt_req_strb = '0;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {29'b0, if_rsp_valid, dt_rsp_valid, ext_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", {29'b0, if_rsp_valid, dt_rsp_valid, ext_req_valid}, 32'd0);

    // R4: fill every word through the data side
    for (int w = 0; w < WORDS; w++) begin
      mdl[w] = 32'h1000_0000 + 32'(w) * 32'h0101_0101;
      dt_tcm(waddr(w), 1'b1, mdl[w], 4'hF, rd);
    end
    for (int w = 0; w < WORDS; w++) begin
      dt_tcm(waddr(w), 1'b0, '0, 4'h0, rd);
      check("R4 data readback", rd, mdl[w]);
    end
    // R5: all 16 strobe patterns
    for (int s = 0; s < 16; s++) begin
      wd = ~mdl[s];
      dt_tcm(waddr(s), 1'b1, wd, 4'(s), rd);
      mdl[s] = merge(mdl[s], wd, 4'(s));
      dt_tcm(waddr(s), 1'b0, '0, 4'h0, rd);
      check("R5 strobe lanes", rd, mdl[s]);
    end
    // R4: fetch side sees the data writes
    for (int w = 0; w < WORDS; w++) begin
      if_tcm(waddr(w), rd);
      check("R4 fetch sees data write", rd, mdl[w]);
    end
    // R6 same word, R3 different words
    for (int w = 0; w < WORDS; w++) begin
      wd = 32'hA000_0000 ^ (32'(w) << 4);
      pair(waddr(w), waddr(w), 1'b1, wd, ird, drd);
      check("R6 fetch gets old word", ird, mdl[w]);
      mdl[w] = wd;
      pair(waddr(w), waddr((w + 5) % WORDS), 1'b0, '0, ird, drd);
      check("R3 fetch data", ird, mdl[w]);
      check("R3 load data", drd, mdl[(w + 5) % WORDS]);
    end
    // R1: window edges
    dt_tcm(BASE, 1'b0, '0, 4'h0, rd);
    check("R1 first word hits", rd, mdl[0]);
    dt_tcm(BASE + 32'(BYTES - 4), 1'b0, '0, 4'h0, rd);
    check("R1 last word hits", rd, mdl[WORDS-1]);
    dt_ext(BASE - 32'd4, 1'b0, '0, 4'h0, rd);
    check("R1 below base external", rd, (BASE - 32'd4) ^ XMASK);
    if_ext(BASE + 32'(BYTES), rd);
    check("R1 past end external", rd, (BASE + 32'(BYTES)) ^ XMASK);
    // R7: external write and reads with several latencies
    ext_lat = 4;
    dt_ext(32'h9000_0010, 1'b1, 32'hCAFE_F00D, 4'b0110, rd);
    for (int l = 0; l < 4; l++) begin
      ext_lat = l;
      dt_ext(32'h8000_0100 + 32'(l * 4), 1'b0, '0, 4'h0, rd);
      check("R7 data ext data", rd, (32'h8000_0100 + 32'(l * 4)) ^ XMASK);
      if_ext(32'h8000_0200 + 32'(l * 4), rd);
      check("R7 fetch ext data", rd, (32'h8000_0200 + 32'(l * 4)) ^ XMASK);
    end

    // R8: simultaneous misses, data first
    ext_lat = 3; a_i = 32'h8000_0040; a_d = 32'h8000_0080;
    @(negedge clk);
    if_req_valid = 1; if_req_addr = a_i;
    dt_req_valid = 1; dt_req_addr = a_d; dt_req_write = 0; dt_req_strb = 0;
    #1;
    check("R8 data ready", 32'(dt_req_ready), 32'd1);
    check("R8 fetch stalled", 32'(if_req_ready), 32'd0);
    check("R8 data address out", ext_req_addr, a_d);
    @(negedge clk);
    dt_req_valid = 0; #1; g = 0; seen = 0;
    while (!if_req_ready && g < 100) begin
      if (dt_rsp_valid) begin seen = 1; check("R8 data rsp", dt_rsp_data, a_d ^ XMASK); end
      @(negedge clk); #1; g++;
    end
    check("R8 data done before fetch", 32'(seen), 32'd1);
    check("R8 fetch address out", ext_req_addr, a_i);
    @(negedge clk);
    if_req_valid = 0; g = 0;
    while (!if_rsp_valid && g < 100) begin @(negedge clk); g++; end
    check("R8 fetch rsp", if_rsp_data, a_i ^ XMASK);

    // R9: waiting request keeps its owner
    ext_lat = 2; ext_req_ready = 0; a_i = 32'h8000_0300; a_d = 32'h8000_0400;
    @(negedge clk);
    if_req_valid = 1; if_req_addr = a_i; #1;
    check("R9 fetch presented", {31'b0, ext_req_valid}, 32'd1);
    check("R9 fetch addr", ext_req_addr, a_i);
    @(negedge clk);
    dt_req_valid = 1; dt_req_addr = a_d; dt_req_write = 0; #1;
    check("R9 owner held", ext_req_addr, a_i);
    check("R9 data waits", 32'(dt_req_ready), 32'd0);
    @(negedge clk);
    ext_req_ready = 1; #1;
    check("R9 held fetch accepted", {30'b0, if_req_ready, dt_req_ready}, 32'd2);
    @(negedge clk);
    if_req_valid = 0; #1;
    check("R9 one in flight", 32'(dt_req_ready), 32'd0);
    g = 0; seen = 0;
    while (!dt_req_ready && g < 100) begin
      if (if_rsp_valid) begin seen = 1; check("R9 fetch rsp", if_rsp_data, a_i ^ XMASK); end
      @(negedge clk); #1; g++;
    end
    check("R9 fetch finished first", 32'(seen), 32'd1);
    check("R9 data addr out", ext_req_addr, a_d);
    @(negedge clk);
    dt_req_valid = 0; g = 0;
    while (!dt_rsp_valid && g < 100) begin @(negedge clk); g++; end
    check("R9 data rsp", dt_rsp_data, a_d ^ XMASK);

    // R10: ordering on the data side, fetch keeps running
    ext_lat = 6; a_d = 32'h8000_0500;
    @(negedge clk);
    dt_req_valid = 1; dt_req_addr = a_d; dt_req_write = 0; #1;
    check("R10 ext accepted", 32'(dt_req_ready), 32'd1);
    @(negedge clk);
    dt_req_addr = waddr(2);
    if_req_valid = 1; if_req_addr = waddr(3); #1;
    check("R10 data blocked", 32'(dt_req_ready), 32'd0);
    check("R10 fetch proceeds", 32'(if_req_ready), 32'd1);
    @(negedge clk);
    if_req_valid = 0;
    check("R10 fetch rsp", if_rsp_data, mdl[3]);
    #1; g = 0; seen = 0;
    while (!dt_req_ready && g < 100) begin
      if (dt_rsp_valid) begin seen = 1; check("R10 ext rsp first", dt_rsp_data, a_d ^ XMASK); end
      @(negedge clk); #1; g++;
    end
    check("R10 ext rsp before hit", 32'(seen), 32'd1);
    @(negedge clk);
    dt_req_valid = 0;
    check("R10 hit rsp", 32'(dt_rsp_valid), 32'd1);
    check("R10 hit data", dt_rsp_data, mdl[2]);

    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule